// File: doc/BRIEF.md
# Aliased Control Register with Merge Writes

This block holds one 64-bit control and status word on a register bus that uses doubleword offsets. The byte address from the bus is shifted right by three to give the offset, so every access moves a whole 64-bit word, and bit 63 is the most significant bit of the data. Software can reach the same stored word through a small group of alias offsets. One offset replaces the word. One offset merges the write data into the word with OR. The third offset depends on the generation. The first generation merges with AND there, and the second clears the word whatever the data is.

Only the top sixteen bits of the word are stored, and the rest always read back as zero. The top stored bit drives a level interrupt output through one register stage. Reads return data one cycle after the request. Only the direct offset gives the stored value, and every other offset reads as zero. An access to an offset that the block does not map changes nothing and raises a one-cycle error pulse.

Top module: `alias_mask_reg`

## Requirements
- R1: After reset the stored word is zero, and `irq`, `rdata`, `rd_valid` and `err` are all low.
- R2: The offset is `addr >> 3`, and `addr[2:0]` is ignored. With `GEN`=0 the direct offset is 0x4020, the AND alias is 0x4021 and the OR alias is 0x4022. With `GEN`=1 the direct offset is 0x6080, the clear alias is 0x6081 and the OR alias is 0x6082.
- R3: A write to the direct offset stores `wdata` with bits 47:0 forced to zero. Bits 47:0 of the word always read as zero.
- R4: A write to the AND alias (`GEN`=0) stores `(word & wdata)` with bits 47:0 forced to zero.
- R5: A write to the OR alias stores `(word | wdata)` with bits 47:0 forced to zero.
- R6: A write to the clear alias (`GEN`=1) sets the word to zero for any `wdata`.
- R7: A read of the direct offset returns the stored word on `rdata`, with `rd_valid` high, in the cycle after the request.
- R8: A read of any other offset, alias offsets included, returns zero on `rdata` in the cycle after the request, with `rd_valid` high.
- R9: A write to an unmapped offset leaves the stored word unchanged.
- R10: `err` is high for exactly the one cycle after an access, read or write, to an unmapped offset. The alias offsets count as mapped.
- R11: `irq` equals bit 63 of the stored word and follows it one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address; offset is addr >> 3 |
| wdata | input | DATA_W | Write data, bit 63 most significant |
| rdata | output | DATA_W | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Read data return, the cycle after a read request |
| err | output | 1 | One-cycle pulse after an unmapped access |
| irq | output | 1 | Level interrupt from the top stored bit |

## Verification
On every cycle, the embedded assertions check the following:
- `irq` lags the top stored bit by exactly one clock.
- The low 48 bits of the word stay zero.
- The word holds whenever no mapped write occurred.
- A clear-alias write leaves zero.
- Read returns are valid for exactly one cycle, and reads from non-direct offsets return zero.
- Every error pulse follows an unmapped request.

Only the bench scenarios can show the actual values the merge writes produce. They also show that each generation decodes its own offsets, so that the other generation's offsets become unmapped. The scenarios cover the address low bits being ignored and the read-back of values after AND, OR and clear sequences.

// File: rtl/acr_pkg.sv
package acr_pkg;

  // What a decoded offset does to the stored word.
  typedef enum logic [2:0] {
    AK_NONE   = 3'd0,
    AK_DIRECT = 3'd1,
    AK_AND    = 3'd2,
    AK_OR     = 3'd3,
    AK_CLEAR  = 3'd4
  } acr_kind_e;

  // Offset of the direct register for each generation; aliases follow it.
  function automatic logic [15:0] base_offset(input int gen);
    return (gen == 0) ? 16'h4020 : 16'h6080;
  endfunction

endpackage

// File: rtl/acr_decode.sv
module acr_decode
  import acr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int GEN    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acr_kind_e         kind,
  output logic              wr_upd,
  output logic              rd_direct,
  output logic              rd_en,
  output logic              err_q
);

  localparam int OFF_W = ADDR_W - 3;
  localparam logic [OFF_W-1:0] OFF_REG = OFF_W'(base_offset(GEN));
  localparam logic [OFF_W-1:0] OFF_SEC = OFF_REG + OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_OR  = OFF_REG + OFF_W'(2);

  logic [OFF_W-1:0] off;
  logic [2:0]       unused_lo;
  acr_kind_e        sec_kind;
  logic             hit;

  // The second alias is an AND merge in generation A and a clear in B.
  generate
    if (GEN == 0) begin : g_gen_a
      assign sec_kind = AK_AND;
    end else begin : g_gen_b
      assign sec_kind = AK_CLEAR;
    end
  endgenerate

  assign off       = addr[ADDR_W-1:3];
  assign unused_lo = addr[2:0];

  always_comb begin
    if (off == OFF_REG)      kind = AK_DIRECT;
    else if (off == OFF_SEC) kind = sec_kind;
    else if (off == OFF_OR)  kind = AK_OR;
    else                     kind = AK_NONE;
  end

  assign hit       = (kind != AK_NONE);
  assign wr_upd    = req & we & hit;
  assign rd_en     = req & ~we;
  assign rd_direct = req & ~we & (kind == AK_DIRECT);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= req & ~hit;
  end

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(req) && ($past(kind) == AK_NONE)));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req) |-> !err_q);

endmodule

// File: rtl/acr_merge.sv
module acr_merge
  import acr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  acr_kind_e         kind,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] nxt
);

  localparam int DROP_W = DATA_W - KEEP_W;
  localparam logic [DATA_W-1:0] KEEP = {{KEEP_W{1'b1}}, {DROP_W{1'b0}}};

  // Merge rule for one update, followed by the storage mask.
  function automatic logic [DATA_W-1:0] combine(input acr_kind_e k,
                                                input logic [DATA_W-1:0] c,
                                                input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] raw;
    case (k)
      AK_DIRECT: raw = w;
      AK_AND:    raw = c & w;
      AK_OR:     raw = c | w;
      AK_CLEAR:  raw = '0;
      default:   raw = c;
    endcase
    return raw & KEEP;
  endfunction

  assign nxt = combine(kind, cur, wd);

endmodule

// File: rtl/acr_store.sv
module acr_store #(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] nxt,
  input  logic              rd_en,
  input  logic              rd_direct,
  output logic [DATA_W-1:0] misc_q,
  output logic              irq_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rd_valid_q
);

  localparam int DROP_W = DATA_W - KEEP_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q     <= '0;
      irq_q      <= 1'b0;
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (upd) misc_q <= nxt;
      irq_q      <= misc_q[DATA_W-1];
      rd_valid_q <= rd_en;
      rdata_q    <= rd_direct ? misc_q : '0;
    end
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(misc_q[DATA_W-1]));

  // R3
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc_q[DROP_W-1:0] == '0);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) |-> (misc_q == $past(misc_q)));

endmodule

// File: rtl/alias_mask_reg.sv
module alias_mask_reg
  import acr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16,
  parameter int GEN    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              err,
  output logic              irq
);

  acr_kind_e         kind;
  logic              wr_upd;
  logic              rd_direct;
  logic              rd_en;
  logic [DATA_W-1:0] misc_q;
  logic [DATA_W-1:0] nxt;

  acr_decode #(.ADDR_W(ADDR_W), .GEN(GEN)) u_decode (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .kind(kind), .wr_upd(wr_upd), .rd_direct(rd_direct), .rd_en(rd_en),
    .err_q(err)
  );

  acr_merge #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_merge (
    .kind(kind), .cur(misc_q), .wd(wdata), .nxt(nxt)
  );

  acr_store #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .upd(wr_upd), .nxt(nxt),
    .rd_en(rd_en), .rd_direct(rd_direct),
    .misc_q(misc_q), .irq_q(irq), .rdata_q(rdata), .rd_valid_q(rd_valid)
  );

  // R7
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(req && !we));

  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(rd_direct)) |-> (rdata == '0));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_upd && (kind == AK_CLEAR)) |-> (misc_q == '0));

endmodule

// File: tb/alias_mask_reg_test.sv
`timescale 1ns/1ps
module alias_mask_reg_test;

  localparam int AW = 20;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;

  logic [DW-1:0] rdata_a, rdata_b;
  logic          rv_a, rv_b, err_a, err_b, irq_a, irq_b;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] mdl_a = '0;
  logic [63:0] mdl_b = '0;

  always #2.5 clk = ~clk;

  alias_mask_reg #(.GEN(0)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata_a), .rd_valid(rv_a), .err(err_a), .irq(irq_a)
  );

  alias_mask_reg #(.GEN(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata_b), .rd_valid(rv_b), .err(err_b), .irq(irq_b)
  );

  function automatic logic [19:0] badr(input int off);
    return 20'(off * 8);
  endfunction

  function automatic logic [63:0] kept(input logic [63:0] v);
    return {v[63:48], 48'h0};
  endfunction

  // Independent model of one write: what the word becomes and whether mapped.
  function automatic logic [63:0] model_next(input int gen, input logic [63:0] cur,
                                             input logic [19:0] a, input logic [63:0] d,
                                             output bit mapped);
    int off;
    int base;
    off  = int'(a[19:3]);
    base = (gen != 0) ? 'h6080 : 'h4020;
    mapped = 1'b1;
    if (off == base)     return kept(d);
    if (off == base + 2) return kept(cur | d);
    if (off == base + 1) return (gen != 0) ? 64'h0 : kept(cur & d);
    mapped = 1'b0;
    return cur;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input string tag, input logic [19:0] a, input logic [63:0] d);
    bit ma, mb;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    mdl_a = model_next(0, mdl_a, a, d, ma);
    mdl_b = model_next(1, mdl_b, a, d, mb);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk({tag, " R10 err A after write"}, 64'(err_a), 64'(!ma));
    chk({tag, " R10 err B after write"}, 64'(err_b), 64'(!mb));
  endtask

  task automatic do_read(input string tag, input logic [19:0] a);
    int off;
    logic [63:0] ea, eb;
    bit ma, mb;
    off = int'(a[19:3]);
    ea = (off == 'h4020) ? mdl_a : 64'h0;
    eb = (off == 'h6080) ? mdl_b : 64'h0;
    ma = (off >= 'h4020) && (off <= 'h4022);
    mb = (off >= 'h6080) && (off <= 'h6082);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " rdata A"}, rdata_a, ea);
    chk({tag, " rdata B"}, rdata_b, eb);
    chk({tag, " R7 rd_valid A"}, 64'(rv_a), 64'd1);
    chk({tag, " R7 rd_valid B"}, 64'(rv_b), 64'd1);
    chk({tag, " R10 err A after read"}, 64'(err_a), 64'(!ma));
    chk({tag, " R10 err B after read"}, 64'(err_b), 64'(!mb));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 irq A", 64'(irq_a), 64'd0);
    chk("R1 irq B", 64'(irq_b), 64'd0);
    chk("R1 rd_valid A", 64'(rv_a), 64'd0);
    chk("R1 err B", 64'(err_b), 64'd0);
    chk("R1 rdata A", rdata_a, 64'd0);
    do_read("R1 R7 direct A after reset", badr('h4020));
    do_read("R1 R7 direct B after reset", badr('h6080));
    @(negedge clk);
    chk("R7 rd_valid drops", 64'(rv_a), 64'd0);
  endtask

  task automatic t_direct();
    do_write("R3", badr('h4020), 64'hDEAD_BEEF_1234_5678);
    do_read("R3 R7 direct A", badr('h4020));
    chk("R3 model A", mdl_a, 64'hDEAD_0000_0000_0000);
    do_read("R9 R7 B untouched by A offset", badr('h6080));
  endtask

  task automatic t_irq();
    chk("R11 irq A from direct", 64'(irq_a), 64'd1);
    do_write("R11", badr('h6080), 64'h8001_FFFF_FFFF_FFFF);
    chk("R11 irq B not yet", 64'(irq_b), 64'd0);
    @(negedge clk);
    chk("R11 irq B one clock later", 64'(irq_b), 64'd1);
    do_read("R3 R7 direct B", badr('h6080));
    chk("R3 model B", mdl_b, 64'h8001_0000_0000_0000);
  endtask

  task automatic t_and();
    do_write("R4", badr('h4021), 64'h7FF0_FFFF_FFFF_FFFF);
    chk("R11 irq A before fall", 64'(irq_a), 64'd1);
    do_read("R4 R7 AND result A", badr('h4020));
    chk("R4 model A", mdl_a, 64'h5EA0_0000_0000_0000);
    chk("R11 irq A fell", 64'(irq_a), 64'd0);
    do_read("R9 B unchanged by 0x4021", badr('h6080));
  endtask

  task automatic t_or();
    do_write("R5", badr('h4022), 64'h0000_0000_0000_00FF);
    do_read("R5 R3 low bits dropped", badr('h4020));
    do_write("R5", badr('h4022), 64'h8003_0000_0000_0000);
    do_read("R5 R7 OR result A", badr('h4020));
    chk("R5 model A", mdl_a, 64'hDEA3_0000_0000_0000);
    do_write("R5", badr('h6082), 64'h0100_0000_0000_0001);
    do_read("R5 R7 OR result B", badr('h6080));
    chk("R5 model B", mdl_b, 64'h8101_0000_0000_0000);
    chk("R11 irq A after OR", 64'(irq_a), 64'd1);
  endtask

  task automatic t_clear();
    do_write("R6", badr('h6081), 64'hFFFF_FFFF_FFFF_FFFF);
    do_read("R6 R7 B cleared", badr('h6080));
    chk("R6 model B", mdl_b, 64'h0);
    chk("R11 irq B after clear", 64'(irq_b), 64'd0);
    do_read("R9 A unchanged by 0x6081", badr('h4020));
  endtask

  task automatic t_alias_read();
    do_read("R8 alias 0x4021", badr('h4021));
    do_read("R8 alias 0x4022", badr('h4022));
    do_read("R8 alias 0x6081", badr('h6081));
    do_read("R8 alias 0x6082", badr('h6082));
  endtask

  task automatic t_unmapped();
    logic [63:0] keep_a;
    keep_a = mdl_a;
    do_write("R9", badr('h0), 64'hFFFF_FFFF_FFFF_FFFF);
    do_write("R9", badr('h4023), 64'h0);
    do_write("R9", badr('h607F), 64'hFFFF_0000_0000_0000);
    do_read("R9 R7 A unchanged", badr('h4020));
    do_read("R9 R7 B unchanged", badr('h6080));
    chk("R9 model A kept", mdl_a, keep_a);
    do_read("R8 R10 unmapped read", badr('h1234));
  endtask

  task automatic t_low_bits();
    do_write("R2", badr('h4020) | 20'h5, 64'h1234_5678_9ABC_DEF0);
    do_read("R2 R7 direct A low bits", badr('h4020) | 20'h3);
    chk("R2 model A", mdl_a, 64'h1234_0000_0000_0000);
    do_write("R2", badr('h6082) | 20'h7, 64'h0042_0000_0000_0000);
    do_read("R2 R7 direct B low bits", badr('h6080) | 20'h6);
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_irq();
    t_and();
    t_or();
    t_clear();
    t_alias_read();
    t_unmapped();
    t_low_bits();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule